// File: doc/BRIEF.md
# Error Code Classifier and Alert Router

This block gathers 3-bit error reports from a set of storage-access agents. Agent 0 is the direct-access agent and agent 1 is the life-cycle agent. Agents 2 and up each serve one partition, buffered or unbuffered. For each report the block decides whether the error is recoverable, taking into account which agent raised it and whether the partition is a vendor-test partition. It stores the resulting code in a per-agent status field. It drives a sticky error interrupt and two level fatal alerts: one for faults that start in the storage macro and one for every other unrecoverable fault.

Each agent has its own state machine with three states. CLEAR means no error is held. RECOV means a recoverable code is held. TERM means an unrecoverable code is held. The transitions are as follows:
- CLEAR goes to RECOV on a recoverable nonzero report.
- CLEAR goes to TERM on an unrecoverable report.
- RECOV goes to CLEAR when the agent starts its next operation, or on a report of code 0.
- RECOV stays in RECOV on a new recoverable report, and the new code replaces the old one.
- RECOV goes to TERM on an unrecoverable report.
- TERM is left only by reset.

The partition flags that mark vendor-test partitions are fixed by a parameter.

Top module: `err_router`

## Requirements
- R1: After reset every status field reads 0, no agent is terminal, and `irq_o`, `fatal_macro_o` and `fatal_check_o` are low.
- R2: Codes 2 (correctable ECC) and 5 (access) are recoverable for every agent. On the clock edge that samples the report, the code appears in the agent's status field, the agent does not become terminal, and no alert rises.
- R3: A recoverable code is cleared to 0 on the edge that samples the agent's `op_start_i` bit. If a report arrives in the same cycle, the report wins.
- R4: Code 4 (write-blank) is recoverable when it comes from agent 0. From any other agent it is terminal and raises `fatal_check_o`.
- R5: Codes 1 (macro fault) and 3 (uncorrectable ECC, outside vendor-test partitions) make the agent terminal and raise `fatal_macro_o` but not `fatal_check_o`.
- R6: Codes 6 (check failure) and 7 (state-machine fault) make the agent terminal and raise `fatal_check_o` but not `fatal_macro_o`.
- R7: In a partition whose bit in `VENDOR_MASK` is set (bit k belongs to agent k+2), code 3 is stored as 2 and treated as recoverable.
- R8: A terminal agent ignores further reports and `op_start_i`. Its status field, its `terminal_o` bit and its alert stay unchanged until reset.
- R9: `irq_o` rises on the edge after any accepted nonzero report and stays high until a `irq_clr_i` pulse. A report in the same cycle as the clear wins. A report of code 0 does not raise it.
- R10: The alerts combine all agents, so two agents failing in the same cycle with a macro code and a check code raise both alerts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rep_valid_i | input | NUM_PART+2 | Per-agent report strobe |
| rep_code_i | input | 3*(NUM_PART+2) | Per-agent raw code; agent a uses bits [3a+2:3a] |
| op_start_i | input | NUM_PART+2 | Per-agent start of next operation |
| irq_clr_i | input | 1 | Write-one-to-clear of the interrupt |
| status_code_o | output | 3*(NUM_PART+2) | Latched per-agent code |
| terminal_o | output | NUM_PART+2 | Per-agent terminal state |
| irq_o | output | 1 | Sticky error interrupt |
| fatal_macro_o | output | 1 | Fatal alert for macro-originated faults |
| fatal_check_o | output | 1 | Fatal alert for all other unrecoverable faults |

## Verification
The assertions assume that `rep_valid_i`, `op_start_i` and `irq_clr_i` are synchronous single-cycle strobes with known values after reset. They also assume that a code is only meaningful while its strobe is high. The bench drives every strobe at the falling edge for exactly one cycle, then returns it to zero and the codes to 0. It deliberately places same-cycle collisions of report with start and of report with interrupt clear, because those are the orderings the requirements fix.

// File: rtl/err_router_pkg.sv
package err_router_pkg;

    localparam int CODE_W = 3;

    typedef enum logic [2:0] {
        E_NONE      = 3'h0,
        E_MACRO     = 3'h1,
        E_ECC_CORR  = 3'h2,
        E_ECC_UNC   = 3'h3,
        E_BLANK     = 3'h4,
        E_ACCESS    = 3'h5,
        E_CHECK     = 3'h6,
        E_FSM       = 3'h7
    } err_code_e;

    typedef enum logic [1:0] {
        AGT_DIRECT,
        AGT_LIFECYCLE,
        AGT_PART
    } agent_kind_e;

    typedef enum logic [1:0] {
        S_CLEAR,
        S_RECOV,
        S_TERM
    } slot_state_e;

endpackage

// File: rtl/err_classify.sv
module err_classify
    import err_router_pkg::*;
#(
    parameter agent_kind_e KIND   = AGT_DIRECT,
    parameter bit          VENDOR = 1'b0
) (
    input  logic [CODE_W-1:0] raw_i,
    output logic [CODE_W-1:0] eff_o,
    output logic              recov_o
);

    always_comb begin
        eff_o   = raw_i;
        recov_o = 1'b0;
        unique case (err_code_e'(raw_i))
            E_NONE:     recov_o = 1'b1;
            E_ECC_CORR: recov_o = 1'b1;
            E_ACCESS:   recov_o = 1'b1;
            E_ECC_UNC: begin
                if (KIND == AGT_PART && VENDOR) begin
                    eff_o   = E_ECC_CORR;
                    recov_o = 1'b1;
                end
            end
            E_BLANK:    recov_o = (KIND == AGT_DIRECT);
            E_MACRO, E_CHECK, E_FSM: recov_o = 1'b0;
            default:    recov_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/err_slot.sv
module err_slot
    import err_router_pkg::*;
#(
    parameter agent_kind_e KIND   = AGT_DIRECT,
    parameter bit          VENDOR = 1'b0
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              valid_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              start_i,
    output logic              accept_o,
    output logic [CODE_W-1:0] code_o,
    output logic              term_o,
    output logic              macro_o
);

    slot_state_e       state_q, state_d;
    logic [CODE_W-1:0] code_q, code_d;
    logic [CODE_W-1:0] eff;
    logic              recov;

    err_classify #(.KIND(KIND), .VENDOR(VENDOR)) u_cls (
        .raw_i  (code_i),
        .eff_o  (eff),
        .recov_o(recov)
    );

    always_comb begin
        state_d = state_q;
        code_d  = code_q;
        unique case (state_q)
            S_CLEAR: begin
                if (valid_i && eff != E_NONE) begin
                    state_d = recov ? S_RECOV : S_TERM;
                    code_d  = eff;
                end
            end
            S_RECOV: begin
                if (valid_i) begin
                    code_d = eff;
                    if (eff == E_NONE) state_d = S_CLEAR;
                    else               state_d = recov ? S_RECOV : S_TERM;
                end else if (start_i) begin
                    state_d = S_CLEAR;
                    code_d  = E_NONE;
                end
            end
            S_TERM:  ;
            default: begin
                state_d = S_TERM;
                code_d  = E_FSM;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= S_CLEAR;
            code_q  <= '0;
        end else begin
            state_q <= state_d;
            code_q  <= code_d;
        end
    end

    always_comb begin
        accept_o = valid_i && (state_q != S_TERM) && (eff != E_NONE);
        code_o   = code_q;
        term_o   = (state_q == S_TERM);
        macro_o  = (code_q == E_MACRO) || (code_q == E_ECC_UNC);
    end

    a_r8_term_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        term_o |=> (term_o && $stable(code_o)));

    a_r2_recov_no_term: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && !term_o && (code_i == E_ECC_CORR || code_i == E_ACCESS)) |=> !term_o);

    a_r3_start_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == S_RECOV && start_i && !valid_i) |=> (code_o == E_NONE));

    generate
        if (KIND == AGT_PART && VENDOR) begin : g_vend_chk
            a_r7_vendor_no_unc: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (valid_i && !term_o && code_i == E_ECC_UNC) |=> (!term_o && code_o == E_ECC_CORR));
        end
    endgenerate

endmodule

// File: rtl/err_router.sv
module err_router
    import err_router_pkg::*;
#(
    parameter int                  NUM_PART    = 4,
    parameter logic [NUM_PART-1:0] VENDOR_MASK = 4'b0001
) (
    input  logic                             clk_i,
    input  logic                             rst_ni,
    input  logic [NUM_PART+1:0]              rep_valid_i,
    input  logic [CODE_W*(NUM_PART+2)-1:0]   rep_code_i,
    input  logic [NUM_PART+1:0]              op_start_i,
    input  logic                             irq_clr_i,
    output logic [CODE_W*(NUM_PART+2)-1:0]   status_code_o,
    output logic [NUM_PART+1:0]              terminal_o,
    output logic                             irq_o,
    output logic                             fatal_macro_o,
    output logic                             fatal_check_o
);

    localparam int NUM_AGENTS = NUM_PART + 2;
    localparam logic [NUM_AGENTS-1:0] VEND_ALL = {VENDOR_MASK, 2'b00};

    logic [NUM_AGENTS-1:0] accept;
    logic [NUM_AGENTS-1:0] macro;
    logic                  irq_q;

    generate
        for (genvar a = 0; a < NUM_AGENTS; a++) begin : g_agent
            localparam agent_kind_e KIND_A = (a == 0) ? AGT_DIRECT :
                                             (a == 1) ? AGT_LIFECYCLE : AGT_PART;
            err_slot #(.KIND(KIND_A), .VENDOR(VEND_ALL[a])) u_slot (
                .clk_i   (clk_i),
                .rst_ni  (rst_ni),
                .valid_i (rep_valid_i[a]),
                .code_i  (rep_code_i[a*CODE_W +: CODE_W]),
                .start_i (op_start_i[a]),
                .accept_o(accept[a]),
                .code_o  (status_code_o[a*CODE_W +: CODE_W]),
                .term_o  (terminal_o[a]),
                .macro_o (macro[a])
            );
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        irq_q <= 1'b0;
        else if (|accept)   irq_q <= 1'b1;
        else if (irq_clr_i) irq_q <= 1'b0;
    end

    always_comb begin
        irq_o         = irq_q;
        fatal_macro_o = |(terminal_o & macro);
        fatal_check_o = |(terminal_o & ~macro);
    end

    a_r9_irq_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|accept) |=> irq_o);

    a_r10_macro_needs_term: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fatal_macro_o |-> (|terminal_o));

    a_r8_check_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fatal_check_o |=> fatal_check_o);

    a_r8_macro_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fatal_macro_o |=> fatal_macro_o);

endmodule

// File: tb/err_router_tb_top.sv
module err_router_tb_top;

    localparam int NP = 4;
    localparam int NA = NP + 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NA-1:0]   valid = '0;
    logic [3*NA-1:0] code = '0;
    logic [NA-1:0]   start = '0;
    logic            clr = 1'b0;
    logic [3*NA-1:0] status;
    logic [NA-1:0]   term;
    logic            irq, fmac, fchk;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    err_router #(.NUM_PART(NP), .VENDOR_MASK(4'b0001)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .rep_valid_i(valid), .rep_code_i(code),
        .op_start_i(start), .irq_clr_i(clr), .status_code_o(status),
        .terminal_o(term), .irq_o(irq), .fatal_macro_o(fmac), .fatal_check_o(fchk)
    );

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        valid = '0; code = '0; start = '0; clr = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic rep(input int a, input int c);
        valid[a] = 1'b1;
        code[a*3 +: 3] = 3'(c);
    endtask

    task automatic step();
        @(negedge clk);
        valid = '0; code = '0; start = '0; clr = 1'b0;
    endtask

    function automatic int st(input int a);
        return int'(status[a*3 +: 3]);
    endfunction

    task automatic t_reset();
        do_reset();
        for (int a = 0; a < NA; a++) chk(st(a), 0, "R1 status");
        chk(int'(term), 0, "R1 terminal");
        chk(int'(irq), 0, "R1 irq");
        chk(int'(fmac | fchk), 0, "R1 alerts");
    endtask

    task automatic t_recov();
        do_reset();
        rep(0, 5); step();
        chk(st(0), 5, "R2 access code");
        chk(int'(term[0]), 0, "R2 no terminal");
        chk(int'(fmac | fchk), 0, "R2 no alert");
        chk(int'(irq), 1, "R9 irq set");
        clr = 1'b1; step();
        chk(int'(irq), 0, "R9 irq cleared");
        start[0] = 1'b1; step();
        chk(st(0), 0, "R3 start clears");
        rep(3, 2); step();
        chk(st(3), 2, "R2 corr ecc");
        start[3] = 1'b1; rep(3, 5); step();
        chk(st(3), 5, "R3 report wins over start");
    endtask

    task automatic t_blank();
        do_reset();
        rep(0, 4); step();
        chk(st(0), 4, "R4 direct blank code");
        chk(int'(term[0]), 0, "R4 direct blank recoverable");
        chk(int'(fchk), 0, "R4 no check alert");
        rep(1, 4); step();
        chk(int'(term[1]), 1, "R4 lifecycle blank terminal");
        chk(int'(fchk), 1, "R4 check alert");
        chk(int'(fmac), 0, "R4 no macro alert");
    endtask

    task automatic t_macro();
        do_reset();
        rep(4, 3); step();
        chk(st(4), 3, "R5 unc code");
        chk(int'(term[4]), 1, "R5 unc terminal");
        chk(int'(fmac), 1, "R5 macro alert");
        chk(int'(fchk), 0, "R5 no check alert");
        do_reset();
        rep(0, 1); step();
        chk(int'(term[0]), 1, "R5 macro terminal");
        chk(int'(fmac), 1, "R5 macro alert code1");
    endtask

    task automatic t_check();
        do_reset();
        rep(5, 7); step();
        chk(int'(term[5]), 1, "R6 fsm terminal");
        chk(int'(fchk), 1, "R6 check alert");
        chk(int'(fmac), 0, "R6 no macro alert");
        do_reset();
        rep(3, 6); step();
        chk(int'(fchk), 1, "R6 checkfail alert");
    endtask

    task automatic t_vendor();
        do_reset();
        rep(2, 3); step();
        chk(st(2), 2, "R7 remapped code");
        chk(int'(term[2]), 0, "R7 not terminal");
        chk(int'(fmac), 0, "R7 no macro alert");
    endtask

    task automatic t_term_hold();
        do_reset();
        rep(5, 7); step();
        clr = 1'b1; step();
        chk(int'(irq), 0, "R9 cleared before hold");
        rep(5, 5); start[5] = 1'b1; step();
        chk(st(5), 7, "R8 status held");
        chk(int'(term[5]), 1, "R8 still terminal");
        chk(int'(irq), 0, "R8 ignored report no irq");
        repeat (3) step();
        chk(int'(fchk), 1, "R8 alert held");
    endtask

    task automatic t_irq_prio();
        do_reset();
        rep(0, 5); clr = 1'b1; step();
        chk(int'(irq), 1, "R9 set beats clear");
        clr = 1'b1; step();
        rep(0, 0); step();
        chk(int'(irq), 0, "R9 zero code no irq");
        chk(st(0), 0, "R9 zero code clears status");
    endtask

    task automatic t_multi();
        do_reset();
        rep(1, 4); rep(4, 1); step();
        chk(int'(fchk), 1, "R10 check alert");
        chk(int'(fmac), 1, "R10 macro alert");
        chk(int'(term), 6'b010010, "R10 terminal mask");
    endtask

    initial begin
        #4000000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_recov();
        t_blank();
        t_macro();
        t_check();
        t_vendor();
        t_term_hold();
        t_irq_prio();
        t_multi();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule